// File: doc/BRIEF.md
# Fast Ethernet link integrity monitor

This block decides whether a 100 Mbps receive path has a usable link. It sees a flag saying the descrambler has locked, and a per-symbol strobe that marks whether each received symbol is idle. It drives four signals: a live link bit, a latch-low link status bit for management, a one-cycle request to restart auto-negotiation, and a transmit-permit signal.

The link comes up only after lock has been held without a break for a long qualification time. Once up, the link must see a run of at least `IDLE_RUN` consecutive idle symbols inside every supervision window. A window without such a run, or any loss of lock, takes the link down. All timers count clock cycles of the receive-symbol clock. The qualification time and the window length are parameters, so a simulation can use short values. The defaults are 50 ms and 2 ms at 25 MHz.

A management read strobe refreshes the status bit. A link-failure override lets the transmitter run without link, but only while auto-negotiation is disabled.

Top module: `fe_link_monitor`

## Requirements
- R1: While rst_ni is low, link_o, stat_link_o and reneg_o are 0. With auto-negotiation enabled, tx_permit_o is also 0.
- R2: With link down, link_o rises at the clock edge that follows QUAL_CYC consecutive edges at which lock_i was sampled high. It does not rise earlier.
- R3: A single cycle of lock_i low during qualification restarts the count from zero.
- R4: While link is up, every window of WIN_CYC cycles is measured from the edge at which link rose. If such a window saw no run of IDLE_RUN consecutive idle symbols, link_o falls at the edge that ends the window. A symbol counts when sym_vld_i is 1, and it is idle when sym_idle_i is 1.
- R5: A valid non-idle symbol resets the idle run. Cycles with sym_vld_i low neither extend nor break a run. A run that continues past IDLE_RUN keeps satisfying each later window.
- R6: If lock_i is sampled low while link is up, link_o falls at that same edge.
- R7: At a link failure with an_en_i high, reneg_o is 1 for exactly the one cycle in which link_o first reads 0. When an_en_i is low, reneg_o stays 0.
- R8: stat_link_o goes to 0 on a link failure. It stays 0 until an edge with stat_rd_i high and no failure, which loads the current link state.
- R9: tx_permit_o is 1 while link is up. It is also 1 when ovr_i is 1 and an_en_i is 0. In every other case it is 0, and in particular it is 0 whenever link is down with an_en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive-symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Descrambler locked |
| sym_vld_i | input | 1 | A symbol is present this cycle |
| sym_idle_i | input | 1 | The present symbol is idle |
| an_en_i | input | 1 | Auto-negotiation enabled |
| ovr_i | input | 1 | Link-failure override for transmit |
| stat_rd_i | input | 1 | Management read of the status bit |
| link_o | output | 1 | Live link state |
| stat_link_o | output | 1 | Latch-low link status |
| reneg_o | output | 1 | One-cycle renegotiation request |
| tx_permit_o | output | 1 | Transmitter may send data |

## Verification
A fault in the qualification counter would move the rising edge of link_o by one or more cycles after a long run of lock. A fault in the idle-run counter or the window counter would either keep a noisy link alive or drop a clean one. In both cases link_o shows the error at the edge that ends a window, at most WIN_CYC cycles after the fault. Faults in the status latch or in the request logic appear at the edge where a failure or a read takes effect, on stat_link_o and reneg_o. The bench compares all four outputs against its model at every cycle, so each of these faults shows up within one window.

// File: rtl/fe_link_pkg.sv
package fe_link_pkg;
  typedef enum logic {LINK_DOWN = 1'b0, LINK_UP = 1'b1} link_state_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fe_lock_qual.sv
module fe_lock_qual #(
  parameter int unsigned QUAL_CYC = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned QW = fe_link_pkg::cnt_w(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!lock_i || clr_i)   cnt_q <= '0;
    else if (cnt_q != QMAX)      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == QMAX);
endmodule

// File: rtl/fe_idle_window.sv
module fe_idle_window #(
  parameter int unsigned WIN_CYC  = 50000,
  parameter int unsigned IDLE_RUN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  input  logic sym_vld_i,
  input  logic sym_idle_i,
  output logic miss_o
);
  localparam int unsigned WW = fe_link_pkg::cnt_w(WIN_CYC);
  localparam int unsigned RW = fe_link_pkg::cnt_w(IDLE_RUN + 1);
  localparam logic [WW-1:0] WMAX = WW'(WIN_CYC - 1);
  localparam logic [RW-1:0] RMAX = RW'(IDLE_RUN);
  localparam logic [RW-1:0] RHIT = RW'(IDLE_RUN - 1);

  logic [WW-1:0] win_q;
  logic [RW-1:0] run_q;
  logic          seen_q;
  logic          hit, win_end;

  // hit: this symbol completes or extends a qualifying run
  assign hit     = sym_vld_i && sym_idle_i && (run_q >= RHIT);
  assign win_end = run_en_i && (win_q == WMAX);
  assign miss_o  = win_end && !(seen_q || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (sym_vld_i) begin
      if (!sym_idle_i)        run_q <= '0;
      else if (run_q != RMAX) run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_en_i || win_end) begin
      win_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      win_q  <= win_q + 1'b1;
      seen_q <= seen_q || hit;
    end
  end
endmodule

// File: rtl/fe_link_stat.sv
module fe_link_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic rd_i,
  input  logic link_i,
  output logic stat_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (fail_i) stat_q <= 1'b0;
    else if (rd_i)   stat_q <= link_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/fe_link_monitor.sv
module fe_link_monitor #(
  parameter int unsigned QUAL_CYC = 1250000,
  parameter int unsigned WIN_CYC  = 50000,
  parameter int unsigned IDLE_RUN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic sym_vld_i,
  input  logic sym_idle_i,
  input  logic an_en_i,
  input  logic ovr_i,
  input  logic stat_rd_i,
  output logic link_o,
  output logic stat_link_o,
  output logic reneg_o,
  output logic tx_permit_o
);
  import fe_link_pkg::*;

  link_state_e state_q;
  logic        is_up, qual_done, win_miss, go_up, fail, reneg_q;

  assign is_up = (state_q == LINK_UP);

  fe_lock_qual #(.QUAL_CYC(QUAL_CYC)) i_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_i),
    .clr_i  (is_up),
    .done_o (qual_done)
  );

  fe_idle_window #(.WIN_CYC(WIN_CYC), .IDLE_RUN(IDLE_RUN)) i_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_en_i   (is_up),
    .sym_vld_i  (sym_vld_i),
    .sym_idle_i (sym_idle_i),
    .miss_o     (win_miss)
  );

  assign go_up = !is_up && lock_i && qual_done;
  assign fail  = is_up && (!lock_i || win_miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_DOWN;
      reneg_q <= 1'b0;
    end else begin
      reneg_q <= fail && an_en_i;
      if (fail)       state_q <= LINK_DOWN;
      else if (go_up) state_q <= LINK_UP;
    end
  end

  fe_link_stat i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fail_i (fail),
    .rd_i   (stat_rd_i),
    .link_i (is_up),
    .stat_o (stat_link_o)
  );

  assign link_o      = is_up;
  assign reneg_o     = reneg_q;
  // override only while negotiation does not own the line
  assign tx_permit_o = is_up || (ovr_i && !an_en_i);
endmodule

// File: rtl/fe_link_monitor_chk.sv
module fe_link_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_i,
  input logic an_en_i,
  input logic link_o,
  input logic stat_link_o,
  input logic reneg_o,
  input logic tx_permit_o
);
  // R6
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_o && !lock_i) |=> !link_o);

  // R2
  rise_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> $past(lock_i));

  // R7
  reneg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reneg_o |=> !reneg_o);

  // R7
  reneg_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reneg_o |-> ($fell(link_o) && $past(an_en_i)));

  // R8
  stat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_o) |-> !stat_link_o);

  // R9
  tx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_o && an_en_i) |-> !tx_permit_o);

  // R9
  tx_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> tx_permit_o);
endmodule

bind fe_link_monitor fe_link_monitor_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_i      (lock_i),
  .an_en_i     (an_en_i),
  .link_o      (link_o),
  .stat_link_o (stat_link_o),
  .reneg_o     (reneg_o),
  .tx_permit_o (tx_permit_o)
);

// File: tb/test_fe_link_monitor.sv
module test_fe_link_monitor;
  localparam int CLK_P = 10;
  localparam int QUAL_T = 20;
  localparam int WIN_T = 40;
  localparam int RUN_T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0, vld = 1'b0, idle = 1'b0, an = 1'b1, ovr = 1'b0, rd = 1'b0;
  logic link_o, stat_link_o, reneg_o, tx_permit_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  bit m_link, m_stat, m_reneg, m_seen;
  int m_qual, m_win, m_run;

  always #(CLK_P/2) clk = ~clk;

  fe_link_monitor #(.QUAL_CYC(QUAL_T), .WIN_CYC(WIN_T), .IDLE_RUN(RUN_T)) i_fe_link_monitor (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .sym_vld_i(vld), .sym_idle_i(idle),
    .an_en_i(an), .ovr_i(ovr), .stat_rd_i(rd),
    .link_o(link_o), .stat_link_o(stat_link_o), .reneg_o(reneg_o), .tx_permit_o(tx_permit_o)
  );

  function automatic bit exp_tx(bit l, bit o, bit a);
    return l || (o && !a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_link = 0; m_stat = 0; m_reneg = 0; m_seen = 0;
      m_qual = 0; m_win = 0; m_run = 0;
    end else begin
      bit hit, wend, fl, up;
      hit  = vld && idle && (m_run >= RUN_T - 1);
      wend = m_link && (m_win == WIN_T - 1);
      fl   = m_link && (!lock || (wend && !(m_seen || hit)));
      up   = !m_link && lock && (m_qual == QUAL_T);
      m_reneg = fl && an;
      m_stat  = fl ? 1'b0 : (rd ? m_link : m_stat);
      if (!m_link || wend) begin m_win = 0; m_seen = 0; end
      else begin m_win = m_win + 1; m_seen = m_seen || hit; end
      if (vld) m_run = !idle ? 0 : (m_run == RUN_T ? RUN_T : m_run + 1);
      if (m_link || !lock) m_qual = 0;
      else if (m_qual != QUAL_T) m_qual = m_qual + 1;
      if (fl) m_link = 0; else if (up) m_link = 1;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(link_o, m_link, tag);
    chk(stat_link_o, m_stat, "R8");
    chk(reneg_o, m_reneg, "R7");
    chk(tx_permit_o, exp_tx(m_link, ovr, an), "R9");
  endtask

  task automatic step(input bit l, input bit v, input bit i, input bit a,
                      input bit o, input bit r, input string tag);
    @(negedge clk);
    compare(tag);
    lock = l; vld = v; idle = i; an = a; ovr = o; rd = r;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int first_up;
    void'($urandom(32'd917));
    repeat (3) @(negedge clk);
    // R1
    chk(link_o, 1'b0, "R1");
    chk(stat_link_o, 1'b0, "R1");
    chk(reneg_o, 1'b0, "R1");
    chk(tx_permit_o, 1'b0, "R1");
    rst_n = 1'b1;

    // R3: break lock one cycle before qualification would finish
    for (int k = 0; k < QUAL_T - 2; k++) step(1, 1, 1, 1, 0, 0, "R3");
    step(0, 1, 1, 1, 0, 0, "R3");
    first_up = 0;
    // R2: count steps until link is seen
    for (int k = 1; k <= QUAL_T + 5; k++) begin
      step(1, 1, 1, 1, 0, 0, "R2");
      if (link_o && first_up == 0) first_up = k;
    end
    chk(first_up == QUAL_T + 2, 1'b1, "R2");

    // R4: clean idle traffic keeps the link through several windows
    for (int k = 0; k < 3 * WIN_T; k++) step(1, (k % 4) != 0, 1, 1, 0, (k % 10) == 0, "R4");
    chk(link_o, 1'b1, "R4");

    // R5: runs of RUN_T-1 idles broken by data drop the link at window end
    for (int k = 0; k < 2 * WIN_T + 2; k++)
      step(1, 1, (k % RUN_T) != RUN_T - 1, 1, 0, 0, "R5");
    chk(link_o, 1'b0, "R5");
    chk(stat_link_o, 1'b0, "R8");

    // R5: gaps without symbols do not break a run
    for (int k = 0; k < QUAL_T + 2; k++) step(1, 1, 1, 0, 0, 0, "R2");
    for (int k = 0; k < 2 * WIN_T; k++)
      step(1, (k % 3) != 2, 1, 0, 0, (k % 7) == 0, "R5");
    chk(link_o, 1'b1, "R5");
    chk(stat_link_o, 1'b1, "R8");

    // R6 with negotiation off: no request
    step(0, 1, 1, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 0, 0, "R6");
    chk(link_o, 1'b0, "R6");
    chk(reneg_o, 1'b0, "R7");

    // R9: override honoured only with negotiation disabled
    step(0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 1, 0, "R9");
    chk(tx_permit_o, 1'b1, "R9");
    step(0, 0, 0, 1, 1, 0, "R9");
    step(0, 0, 0, 1, 1, 0, "R9");
    chk(tx_permit_o, 1'b0, "R9");

    // R7: lock loss with negotiation on
    for (int k = 0; k < QUAL_T + 3; k++) step(1, 1, 1, 1, 0, 0, "R2");
    step(0, 1, 1, 1, 0, 0, "R6");
    step(0, 1, 1, 1, 0, 0, "R7");
    chk(reneg_o, 1'b1, "R7");
    step(0, 1, 1, 1, 0, 0, "R7");
    chk(reneg_o, 1'b0, "R7");

    // random mix
    for (int ph = 0; ph < 12; ph++) begin
      bit a = $urandom_range(1, 0) == 1;
      bit o = $urandom_range(1, 0) == 1;
      int p_idle = (ph % 3 == 0) ? 70 : 97;
      for (int k = 0; k < 350; k++) begin
        bit l = $urandom_range(399, 0) != 0;
        step(l, $urandom_range(3, 0) != 0, $urandom_range(99, 0) < p_idle,
             a, o, $urandom_range(15, 0) == 0, "R4");
      end
    end
    @(negedge clk);
    compare("R4");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule